// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a memory-mapped watchdog for a slow (about 32 kHz) functional clock. A 32-bit counter counts up from a programmable load value. When it passes 0xFFFFFFFF it raises an overflow event, drives a reset request for a fixed number of cycles and reloads itself. Software keeps the system alive by writing a changed value to a trigger register, which copies the load value back into the counter.

Starting and stopping the counter takes two key words written in a fixed order. A single stray write can therefore neither disable nor enable the watchdog. The registers that the counting logic uses are written through synchronising slots. Each slot reports a pending bit until its write takes effect after a fixed latency, and software polls that bit before writing the same register again. The block also has a prescaler, a delay-compare event, interrupt enable and status registers, and a self-clearing soft reset.

Top module: `wdog_keyed`

## Requirements
- R1: After rst_n is asserted, the counter and LOAD read 0, the counter is stopped, CTRL (address 5; bit0 = prescale enable, bits 3:1 = PTV) reads 1, PEND reads 0, and irq_o and wd_rst_o are low. The ID register (address 0) always reads REV_ID (default 0x00510203) and ignores writes.
- R2: A write to CTRL (5), COUNT (6), LOAD (7), TRIG (8), KEY (9) or DELAY (11) sets that register's bit in PEND (address 10; bit0 CTRL, bit1 COUNT, bit2 LOAD, bit3 TRIG, bit4 KEY, bit5 DELAY) for SYNC_LAT cycles. The new value takes effect in the cycle the bit clears, and a write to a register whose bit is still set is dropped.
- R3: The KEY word 0x0000AAAA followed by 0x00005555 stops the counter. A stopped counter holds its value.
- R4: The KEY word 0x0000BBBB followed by 0x00004444 starts the counter.
- R5: A second key word that does not complete the pair returns the key sequence to idle and leaves the run state unchanged. A second word with no first word before it does nothing.
- R6: A running counter advances once per clock when CTRL bit0 is 0, and once every 2^PTV clocks when CTRL bit0 is 1.
- R7: A TRIG write whose value differs from the current TRIG contents copies LOAD into the counter. A TRIG write of the same value does not change the counter.
- R8: A tick with the counter at 0xFFFFFFFF loads LOAD into the counter and sets STAT (address 2) bit0. A LOAD of 2^32 − N therefore overflows N ticks after a reload.
- R9: wd_rst_o is high for exactly RST_CYC cycles (default 4), starting in the cycle after an overflow.
- R10: An increment that brings the counter to the DELAY value sets STAT bit1.
- R11: irq_o is high exactly when a STAT bit and its enable are both set. ENSET (3) sets enables on written 1s and ENCLR (4) clears them on written 1s; both read the enables. Writing 1 to a STAT bit clears it.
- R12: Writing 1 to SYSC (address 1) bit0 makes that bit read 1 for SR_LAT cycles and returns every register to its reset state; the bit then clears. Bus writes are ignored in the meantime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_o | output | 1 | Interrupt request |
| wd_rst_o | output | 1 | Watchdog reset request pulse |

## Verification
The bound checker covers the cycle-level consequences of internal events on every cycle:
- an overflow reloads LOAD, sets the status bit and raises the reset pulse on the next cycle;
- a delay hit sets its status bit;
- a stopped counter holds;
- the run state changes only after a key word is applied or during soft reset;
- a pending bit rises only after an accepted write;
- soft reset clears the counter and status.

Some behaviour depends on a sequence of bus operations, and only the bench scenarios show it:
- the exact number of ticks from a load value to overflow;
- the pulse width;
- prescaler rates for each PTV;
- the dropping of writes while a register is pending;
- the rejection of broken key pairs.

// File: rtl/wdk_pkg.sv
`timescale 1ns/1ps
package wdk_pkg;
  localparam int DW    = 32;
  localparam int AW    = 4;
  localparam int NSYNC = 6;

  // register word addresses
  localparam logic [AW-1:0] A_ID    = 4'd0;
  localparam logic [AW-1:0] A_SYSC  = 4'd1;
  localparam logic [AW-1:0] A_STAT  = 4'd2;
  localparam logic [AW-1:0] A_ENSET = 4'd3;
  localparam logic [AW-1:0] A_ENCLR = 4'd4;
  localparam logic [AW-1:0] A_CTRL  = 4'd5;
  localparam logic [AW-1:0] A_CNT   = 4'd6;
  localparam logic [AW-1:0] A_LOAD  = 4'd7;
  localparam logic [AW-1:0] A_TRIG  = 4'd8;
  localparam logic [AW-1:0] A_KEY   = 4'd9;
  localparam logic [AW-1:0] A_PEND  = 4'd10;
  localparam logic [AW-1:0] A_DLY   = 4'd11;

  // synchronising slot indices (also PEND bit positions)
  localparam int S_CTRL = 0;
  localparam int S_CNT  = 1;
  localparam int S_LOAD = 2;
  localparam int S_TRIG = 3;
  localparam int S_KEY  = 4;
  localparam int S_DLY  = 5;

  localparam logic [DW-1:0] KEY_HALT_1 = 32'h0000_AAAA;
  localparam logic [DW-1:0] KEY_HALT_2 = 32'h0000_5555;
  localparam logic [DW-1:0] KEY_GO_1   = 32'h0000_BBBB;
  localparam logic [DW-1:0] KEY_GO_2   = 32'h0000_4444;

  typedef enum logic [1:0] {K_IDLE, K_HALF_HALT, K_HALF_GO} key_st_e;

  function automatic logic [AW-1:0] slot_addr(input int s);
    case (s)
      S_CTRL:  return A_CTRL;
      S_CNT:   return A_CNT;
      S_LOAD:  return A_LOAD;
      S_TRIG:  return A_TRIG;
      S_KEY:   return A_KEY;
      default: return A_DLY;
    endcase
  endfunction

  // load value giving a timeout of n ticks
  function automatic logic [DW-1:0] load_for_ticks(input logic [DW-1:0] n);
    return '0 - n;
  endfunction

  function automatic logic at_wrap(input logic [DW-1:0] c);
    return c == '1;
  endfunction
endpackage

// File: rtl/wdk_sync_slot.sv
`timescale 1ns/1ps
module wdk_sync_slot #(
  parameter int W   = 32,
  parameter int LAT = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic         pend,
  output logic         apply,
  output logic [W-1:0] data
);
  localparam int CW = $clog2(LAT + 1);
  logic [CW-1:0] cnt_q;

  assign pend  = cnt_q != '0;
  assign apply = cnt_q == CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      data  <= '0;
    end else if (clr) begin
      cnt_q <= '0;
      data  <= '0;
    end else if (wr && !pend) begin
      cnt_q <= CW'(LAT);
      data  <= wdata;
    end else if (pend) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/wdk_prescaler.sv
`timescale 1ns/1ps
module wdk_prescaler #(
  parameter int PTV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic             pre_en,
  input  logic [PTV_W-1:0] ptv,
  output logic             tick
);
  localparam int CW = (1 << PTV_W) - 1;
  logic [CW-1:0] pc_q;
  logic [CW-1:0] lim;

  assign lim  = (CW'(1) << ptv) - CW'(1);
  assign tick = run && (!pre_en || pc_q >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     pc_q <= '0;
    else if (clr || !run || !pre_en) pc_q <= '0;
    else if (pc_q >= lim)           pc_q <= '0;
    else                            pc_q <= pc_q + CW'(1);
  end
endmodule

// File: rtl/wdk_key_fsm.sv
`timescale 1ns/1ps
module wdk_key_fsm import wdk_pkg::*; #(
  parameter bit RUN_INIT = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          apply,
  input  logic [DW-1:0] word,
  output logic          running
);
  key_st_e st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= K_IDLE;
      running <= RUN_INIT;
    end else if (clr) begin
      st_q    <= K_IDLE;
      running <= RUN_INIT;
    end else if (apply) begin
      case (st_q)
        K_IDLE: begin
          if (word == KEY_HALT_1)    st_q <= K_HALF_HALT;
          else if (word == KEY_GO_1) st_q <= K_HALF_GO;
          else                       st_q <= K_IDLE;
        end
        K_HALF_HALT: begin
          if (word == KEY_HALT_2) running <= 1'b0;
          st_q <= K_IDLE;
        end
        default: begin
          if (word == KEY_GO_2) running <= 1'b1;
          st_q <= K_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/wdk_stretch.sv
`timescale 1ns/1ps
module wdk_stretch #(
  parameter int CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic fire,
  output logic out
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt_q;

  assign out = cnt_q != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (clr)      cnt_q <= '0;
    else if (fire)     cnt_q <= CW'(CYC);
    else if (out)      cnt_q <= cnt_q - CW'(1);
  end
endmodule

// File: rtl/wdog_keyed.sv
`timescale 1ns/1ps
module wdog_keyed import wdk_pkg::*; #(
  parameter int          SYNC_LAT     = 3,
  parameter int          RST_CYC      = 4,
  parameter int          SR_LAT       = 2,
  parameter int          PTV_W        = 3,
  parameter logic [31:0] REV_ID       = 32'h0051_0203,
  parameter bit          RUN_AT_RESET = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq_o,
  output logic        wd_rst_o
);
  localparam int CTRL_W = PTV_W + 1;
  localparam int SRW    = $clog2(SR_LAT + 1);
  localparam logic [CTRL_W-1:0] CTRL_RST = CTRL_W'(1);

  // soft reset sequencer
  logic [SRW-1:0] sr_q;
  logic           busy;
  logic           wr_acc;
  assign busy   = sr_q != '0;
  assign wr_acc = bus_sel && bus_wr && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                      sr_q <= '0;
    else if (busy)                                   sr_q <= sr_q - SRW'(1);
    else if (wr_acc && bus_addr == A_SYSC && bus_wdata[0]) sr_q <= SRW'(SR_LAT);
  end

  // synchronising slots
  logic [NSYNC-1:0] slot_wr, slot_pend, slot_apply;
  logic [DW-1:0]    slot_data [NSYNC];

  for (genvar i = 0; i < NSYNC; i++) begin : g_slot
    assign slot_wr[i] = wr_acc && (bus_addr == slot_addr(i));
    wdk_sync_slot #(.W(DW), .LAT(SYNC_LAT)) u_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (busy),
      .wr    (slot_wr[i]),
      .wdata (bus_wdata),
      .pend  (slot_pend[i]),
      .apply (slot_apply[i]),
      .data  (slot_data[i])
    );
  end

  logic [DW-CTRL_W-1:0] unused_ctrl_hi;
  assign unused_ctrl_hi = slot_data[S_CTRL][DW-1:CTRL_W];

  // applied register copies
  logic [CTRL_W-1:0] ctrl_q;
  logic [DW-1:0]     load_q, trig_q, dly_q, cnt_q;
  logic [1:0]        stat_q, en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      load_q <= '0;
      trig_q <= '0;
      dly_q  <= '0;
    end else if (busy) begin
      ctrl_q <= CTRL_RST;
      load_q <= '0;
      trig_q <= '0;
      dly_q  <= '0;
    end else begin
      if (slot_apply[S_CTRL]) ctrl_q <= slot_data[S_CTRL][CTRL_W-1:0];
      if (slot_apply[S_LOAD]) load_q <= slot_data[S_LOAD];
      if (slot_apply[S_TRIG]) trig_q <= slot_data[S_TRIG];
      if (slot_apply[S_DLY])  dly_q  <= slot_data[S_DLY];
    end
  end

  // run control
  logic running;
  logic key_apply;
  assign key_apply = slot_apply[S_KEY];

  wdk_key_fsm #(.RUN_INIT(RUN_AT_RESET)) u_key (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (busy),
    .apply   (key_apply),
    .word    (slot_data[S_KEY]),
    .running (running)
  );

  logic tick;
  wdk_prescaler #(.PTV_W(PTV_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (busy),
    .run    (running),
    .pre_en (ctrl_q[0]),
    .ptv    (ctrl_q[CTRL_W-1:1]),
    .tick   (tick)
  );

  // counter events, brought out for the checker
  logic cnt_wr, trig_reload, ovf_evt, inc_evt, dly_evt;
  logic [DW-1:0] cnt_inc;
  assign cnt_wr      = slot_apply[S_CNT];
  assign trig_reload = slot_apply[S_TRIG] && (slot_data[S_TRIG] != trig_q);
  assign cnt_inc     = cnt_q + DW'(1);
  assign ovf_evt     = !busy && tick && !cnt_wr && !trig_reload && at_wrap(cnt_q);
  assign inc_evt     = !busy && tick && !cnt_wr && !trig_reload && !at_wrap(cnt_q);
  assign dly_evt     = inc_evt && (cnt_inc == dly_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (busy)         cnt_q <= '0;
    else if (cnt_wr)       cnt_q <= slot_data[S_CNT];
    else if (trig_reload)  cnt_q <= load_q;
    else if (ovf_evt)      cnt_q <= load_q;
    else if (inc_evt)      cnt_q <= cnt_inc;
  end

  // interrupt status and enables
  logic [1:0] stat_w1c, en_set, en_clr;
  assign stat_w1c = (wr_acc && bus_addr == A_STAT)  ? bus_wdata[1:0] : 2'b00;
  assign en_set   = (wr_acc && bus_addr == A_ENSET) ? bus_wdata[1:0] : 2'b00;
  assign en_clr   = (wr_acc && bus_addr == A_ENCLR) ? bus_wdata[1:0] : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
    end else if (busy) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= (stat_q & ~stat_w1c) | {dly_evt, ovf_evt};
      en_q   <= (en_q | en_set) & ~en_clr;
    end
  end

  assign irq_o = |(stat_q & en_q);

  wdk_stretch #(.CYC(RST_CYC)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (busy),
    .fire  (ovf_evt),
    .out   (wd_rst_o)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_ID:    bus_rdata = REV_ID;
      A_SYSC:  bus_rdata = {31'b0, busy};
      A_STAT:  bus_rdata = {30'b0, stat_q};
      A_ENSET: bus_rdata = {30'b0, en_q};
      A_ENCLR: bus_rdata = {30'b0, en_q};
      A_CTRL:  bus_rdata = DW'(ctrl_q);
      A_CNT:   bus_rdata = cnt_q;
      A_LOAD:  bus_rdata = load_q;
      A_TRIG:  bus_rdata = trig_q;
      A_PEND:  bus_rdata = DW'(slot_pend);
      A_DLY:   bus_rdata = dly_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdk_checks.sv
`timescale 1ns/1ps
module wdk_checks (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        wr_acc,
  input logic        running,
  input logic        key_apply,
  input logic        cnt_wr,
  input logic        trig_reload,
  input logic        ovf_evt,
  input logic        dly_evt,
  input logic [31:0] cnt_q,
  input logic [31:0] load_q,
  input logic [1:0]  stat_q,
  input logic [5:0]  slot_pend,
  input logic        irq_o,
  input logic        wd_rst_o
);
  p_pend_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(slot_pend & ~$past(slot_pend))) |-> $past(wr_acc));

  p_stop_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !busy && !cnt_wr && !trig_reload) |=> (cnt_q == $past(cnt_q)));

  p_run_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (running != $past(running)) |-> ($past(key_apply) || $past(busy)));

  p_ovf_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (cnt_q == $past(load_q)));

  p_ovf_stat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> stat_q[0]);

  p_rst_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> wd_rst_o);

  p_dly_stat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dly_evt |=> stat_q[1]);

  p_irq_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (stat_q != 2'b00));

  p_srst_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (cnt_q == 32'd0 && !running && stat_q == 2'b00 && !wd_rst_o));
endmodule

bind wdog_keyed wdk_checks u_wdk_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .wr_acc      (wr_acc),
  .running     (running),
  .key_apply   (key_apply),
  .cnt_wr      (cnt_wr),
  .trig_reload (trig_reload),
  .ovf_evt     (ovf_evt),
  .dly_evt     (dly_evt),
  .cnt_q       (cnt_q),
  .load_q      (load_q),
  .stat_q      (stat_q),
  .slot_pend   (slot_pend),
  .irq_o       (irq_o),
  .wd_rst_o    (wd_rst_o)
);

// File: tb/test_wdog_keyed.sv
`timescale 1ns/1ps
module test_wdog_keyed;
  localparam int CLK_P = 10;
  localparam int RSTC  = 4;
  localparam logic [31:0] REV = 32'h0051_0203;
  localparam logic [3:0] AD_ID = 4'd0, AD_SYSC = 4'd1, AD_STAT = 4'd2, AD_ENS = 4'd3,
                         AD_ENC = 4'd4, AD_CTRL = 4'd5, AD_CNT = 4'd6, AD_LOAD = 4'd7,
                         AD_TRIG = 4'd8, AD_KEY = 4'd9, AD_PEND = 4'd10, AD_DLY = 4'd11;

  logic clk = 1'b0, rst_n = 1'b0, sel = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq, wrst;
  int n_chk = 0, n_fail = 0;
  logic [31:0] trig_v = 32'd0;

  always #(CLK_P/2) clk = ~clk;

  wdog_keyed i_wdog_keyed (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq), .wd_rst_o(wrst)
  );

  function automatic logic [31:0] load_for(input logic [31:0] n);
    return 32'h0 - n;
  endfunction

  function automatic int ticks_in(input int cycles, input bit pre, input int ptv);
    return pre ? (cycles >> ptv) : cycles;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd_now(input logic [3:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wait_sync();
    logic [31:0] p;
    for (int i = 0; i < 40; i++) begin
      rd_now(AD_PEND, p);
      if (p == 32'd0) break;
      @(negedge clk);
    end
  endtask

  task automatic wrs(input logic [3:0] a, input logic [31:0] d);
    wr(a, d); wait_sync();
  endtask

  task automatic rate(input int k, output logic [31:0] diff);
    logic [31:0] c0, c1;
    @(negedge clk); rd_now(AD_CNT, c0);
    repeat (k) @(negedge clk);
    rd_now(AD_CNT, c1);
    diff = c1 - c0;
  endtask

  task automatic go();   wrs(AD_KEY, 32'hBBBB); wrs(AD_KEY, 32'h4444); endtask
  task automatic halt(); wrs(AD_KEY, 32'hAAAA); wrs(AD_KEY, 32'h5555); endtask
  task automatic reload(); trig_v = trig_v + 32'd1; wrs(AD_TRIG, trig_v); endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v, c, ld, d;
    int n;
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_now(AD_ID, v);   chk("R1 id", v, REV);
    rd_now(AD_CNT, v);  chk("R1 count", v, 0);
    rd_now(AD_LOAD, v); chk("R1 load", v, 0);
    rd_now(AD_CTRL, v); chk("R1 ctrl", v, 1);
    rd_now(AD_PEND, v); chk("R1 pend", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 wd_rst", {31'b0, wrst}, 0);
    wr(AD_ID, 32'h0); rd_now(AD_ID, v); chk("R1 id write ignored", v, REV);
    rate(10, d); chk("R1 stopped after reset", d, 0);

    // R2 pending and dropped writes
    wr(AD_LOAD, 32'h0000_0ABC);
    rd_now(AD_PEND, v); chk("R2 pend bit2", v, 32'h4);
    rd_now(AD_LOAD, v); chk("R2 not yet applied", v, 0);
    wr(AD_LOAD, 32'h0000_0DEF);
    wait_sync();
    rd_now(AD_LOAD, v); chk("R2 write during pending dropped", v, 32'h0ABC);
    for (int i = 0; i < 6; i++) begin
      c = $urandom;
      wrs(AD_CNT, c); rd_now(AD_CNT, v); chk("R2 count readback", v, c);
    end
    wrs(AD_CNT, 32'd0);

    // R4 / R3 start and stop
    go();   rate(10, d); chk("R4 started", d, 10);
    halt(); rate(10, d); chk("R3 stopped holds", d, 0);

    // R5 broken pairs
    wrs(AD_KEY, 32'hBBBB); wrs(AD_KEY, 32'h1234); wrs(AD_KEY, 32'h4444);
    rate(10, d); chk("R5 bad second word, stays stopped", d, 0);
    go();
    wrs(AD_KEY, 32'hAAAA); wrs(AD_KEY, 32'h0012);
    rate(10, d); chk("R5 bad stop pair, stays running", d, 10);
    wrs(AD_KEY, 32'h5555);
    rate(10, d); chk("R5 lone second word ignored", d, 10);
    halt();

    // R7 trigger reload
    wrs(AD_LOAD, 32'h100); wrs(AD_CNT, 32'h55);
    reload(); rd_now(AD_CNT, v); chk("R7 changed trigger reloads", v, 32'h100);
    wrs(AD_CNT, 32'h77); wrs(AD_TRIG, trig_v);
    rd_now(AD_CNT, v); chk("R7 same trigger no reload", v, 32'h77);

    // R6 prescaler rates, random
    go();
    for (int i = 0; i < 12; i++) begin
      int p; bit pe;
      p = $urandom % 4; pe = 1'($urandom % 2);
      wrs(AD_CTRL, {28'b0, 3'(p), pe});
      repeat (16) @(negedge clk);
      rate(8 << p, d);
      chk("R6 prescaled rate", d, ticks_in(8 << p, pe, p));
    end
    wrs(AD_CTRL, 32'd1);
    halt();

    // R8 / R9 / R11 overflow with interrupt enabled
    wrs(AD_ENS, 32'h1);
    n = 16 + ($urandom % 16);
    ld = load_for(n);
    wrs(AD_LOAD, ld); reload();
    rd_now(AD_CNT, v); chk("R8 reload of timeout value", v, ld);
    go();
    rd_now(AD_CNT, c);
    n = 0;
    while (!wrst && n < 1000) begin @(negedge clk); #1; n++; end
    chk("R8 ticks to overflow", n, 32'h0 - c);
    rd_now(AD_CNT, v); chk("R8 counter reloaded", v, ld);
    rd_now(AD_STAT, v); chk("R8 overflow status", v & 32'h1, 32'h1);
    chk("R11 irq on enabled overflow", {31'b0, irq}, 1);
    n = 0;
    while (wrst && n < 100) begin n++; @(negedge clk); #1; end
    chk("R9 reset pulse width", n, RSTC);
    halt();
    wr(AD_STAT, 32'h3);
    rd_now(AD_STAT, v); chk("R11 status write-1-clear", v, 0);
    chk("R11 irq drops", {31'b0, irq}, 0);

    // R10 delay event
    wrs(AD_ENC, 32'h3); wrs(AD_ENS, 32'h2);
    rd_now(AD_ENS, v); chk("R11 enable set/clear", v, 32'h2);
    wrs(AD_DLY, ld + 32'd7);
    reload(); go();
    rd_now(AD_CNT, c);
    n = 0;
    while (!irq && n < 1000) begin @(negedge clk); #1; n++; end
    chk("R10 cycles to delay hit", n, (ld + 32'd7) - c);
    rd_now(AD_STAT, v); chk("R10 delay status", v, 32'h2);
    halt();
    wr(AD_STAT, 32'h3);

    // R11 overflow with interrupts disabled
    wrs(AD_ENC, 32'h3); wrs(AD_DLY, 32'd0);
    reload(); go();
    n = 0;
    while (!wrst && n < 1000) begin @(negedge clk); #1; n++; end
    rd_now(AD_STAT, v); chk("R11 status set while disabled", v & 32'h1, 32'h1);
    chk("R11 irq masked", {31'b0, irq}, 0);

    // R12 soft reset while running
    wr(AD_SYSC, 32'h1);
    rd_now(AD_SYSC, v); chk("R12 busy reads 1", v, 1);
    wr(AD_LOAD, 32'h5);
    repeat (6) @(negedge clk);
    rd_now(AD_SYSC, v); chk("R12 self clears", v, 0);
    rd_now(AD_CNT, v);  chk("R12 count cleared", v, 0);
    rd_now(AD_LOAD, v); chk("R12 load cleared, write ignored", v, 0);
    rd_now(AD_CTRL, v); chk("R12 ctrl default", v, 1);
    rd_now(AD_STAT, v); chk("R12 status cleared", v, 0);
    rate(10, d); chk("R12 stopped after soft reset", d, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule